// File: doc/BRIEF.md
# I2C Quasi-Bidirectional Port Expander

The block is an I2C target that owns one 8-line quasi-bidirectional port. A controller writes a byte to set the port latch. A latch bit of 1 leaves its line on a weak pull-up, so the line works as an input. A latch bit of 0 drives the line low. A controller reads a byte to get the resolved level of every line. The resolved level is the external level ANDed with the latch bit, so either side can pull a line low.

An active-low interrupt reports that the resolved levels have moved away from the value seen at the last read. A read re-arms the interrupt. A write re-evaluates it against the new levels. The external line inputs pass through a two-flop synchronizer. The I2C clock and data inputs are sampled on the system clock.

The bus itself is the only data path and it paces itself, so the block has no valid/ready stream. Every pin is a plain level.

Top module: `xp_expander`

## Requirements
- R1: After reset the latch, the synchronized input register and the read snapshot all hold 0xFF. `pin_o` is 0xFF, `int_n_o` is 1, and a read with all lines high returns 0xFF.
- R2: A write to the device address (address byte `{DEV_ADDR, 1'b0}`, R/W bit 0 = write) loads the data byte into the latch. `pin_o` then holds the synchronized input ANDed with the new latch.
- R3: A read (address byte `{DEV_ADDR, 1'b1}`) returns, MSB first, the synchronized input ANDed with the latch.
- R4: Traffic for any other address gets no ACK and leaves the latch and `pin_o` unchanged.
- R5: Outside a read or write, a difference between the resolved levels and the snapshot drives `int_n_o` low within 3 clocks of the synchronizer output changing. It stays low after the levels return.
- R6: Each byte loaded for a read copies the resolved levels into the snapshot and sets `int_n_o` to 1.
- R7: After a write, `int_n_o` is 1 if the new resolved levels equal the snapshot and 0 otherwise, including when it was 0 before.
- R8: `pin_o` changes only on a write. Input changes alone never alter it.
- R9: In a multi-byte write, every byte updates the latch in turn, and the last byte remains.
- R10: In a multi-byte read, every byte samples the port afresh when it is loaded. The transfer ends on a controller NACK.
- R11: The target ACKs its own address byte and every data byte written to it, by pulling SDA low during the ninth clock. It does not change SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| pin_i | input | 8 | External level of each port line |
| pin_o | output | 8 | Line level set by the last write |
| int_n_o | output | 1 | Active-low change interrupt |

## Verification
The bench watches for an interrupt that stays low because the write did not re-evaluate it. It also watches for an interrupt that rises again by itself when an input returns to its old level. It checks that `pin_o` does not track input changes between writes, which would mean the output was wired combinationally. A multi-byte read changes the lines between bytes. A design that latched the port only once per transfer would return a stale second byte. A foreign address must get a NACK and must leave the latch untouched, which catches a comparator that ignores the upper address bits.

// File: rtl/xp_pkg.sv
package xp_pkg;
  localparam int XP_LINES = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } xp_state_e;
endpackage

// File: rtl/xp_sync.sv
module xp_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/xp_i2c_target.sv
module xp_i2c_target
  import xp_pkg::*;
#(
  parameter int                 DATA_W   = 8,
  parameter logic [DATA_W-2:0]  DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [DATA_W-1:0] rd_byte,
  output logic              sda_oe,
  output logic              wr_stb,
  output logic [DATA_W-1:0] wr_byte,
  output logic              rd_stb
);
  localparam int             CW       = $clog2(DATA_W + 1);
  localparam logic [CW-1:0]  CNT_FULL = CW'(DATA_W);

  logic [1:0] bus_s;
  logic       scl_s, sda_s, scl_p, sda_p;
  logic       scl_rise, scl_fall, bus_start, bus_stop;

  xp_sync #(.W(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    (bus_s)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

  xp_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q, tx_q;
  logic              rw_q, nack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_byte <= '0;
      rd_stb  <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (bus_start) begin
        state_q <= ST_ADDR;
        cnt_q   <= '0;
        sda_oe  <= 1'b0;
      end else if (bus_stop) begin
        state_q <= ST_IDLE;
        sda_oe  <= 1'b0;
      end else if (scl_rise) begin
        case (state_q)
          ST_ADDR, ST_WR: begin
            sh_q  <= {sh_q[DATA_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end
          ST_RD:     cnt_q  <= cnt_q + 1'b1;
          ST_RD_ACK: nack_q <= sda_s;
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state_q)
          ST_ADDR: begin
            if (cnt_q == CNT_FULL) begin
              if (sh_q[DATA_W-1:1] == DEV_ADDR) begin
                sda_oe  <= 1'b1;
                rw_q    <= sh_q[0];
                state_q <= ST_ADDR_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q    <= rd_byte;
              sda_oe  <= ~rd_byte[DATA_W-1];
              rd_stb  <= 1'b1;
              state_q <= ST_RD;
            end else begin
              sda_oe  <= 1'b0;
              state_q <= ST_WR;
            end
          end
          ST_WR: begin
            if (cnt_q == CNT_FULL) begin
              wr_byte <= sh_q;
              wr_stb  <= 1'b1;
              sda_oe  <= 1'b1;
              state_q <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            sda_oe  <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_WR;
          end
          ST_RD: begin
            if (cnt_q == CNT_FULL) begin
              sda_oe  <= 1'b0;
              state_q <= ST_RD_ACK;
            end else begin
              tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
              sda_oe <= ~tx_q[DATA_W-2];
            end
          end
          ST_RD_ACK: begin
            if (!nack_q) begin
              cnt_q   <= '0;
              tx_q    <= rd_byte;
              sda_oe  <= ~rd_byte[DATA_W-1];
              rd_stb  <= 1'b1;
              state_q <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: the target never moves SDA while SCL stays high
  p_sda_steady_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_p) |=> (!scl_p || $stable(sda_oe) || !scl_s));
endmodule

// File: rtl/xp_port_core.sv
module xp_port_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_sync,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_byte,
  input  logic         rd_stb,
  output logic [W-1:0] rd_byte,
  output logic [W-1:0] pin_out,
  output logic         int_n
);
  logic [W-1:0] latch_q, snap_q, resolved, wr_resolved;

  assign resolved    = pin_sync & latch_q;
  assign wr_resolved = pin_sync & wr_byte;
  assign rd_byte     = resolved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      snap_q  <= '1;
      pin_out <= '1;
      int_n   <= 1'b1;
    end else if (wr_stb) begin
      latch_q <= wr_byte;
      pin_out <= wr_resolved;
      int_n   <= (wr_resolved == snap_q);
    end else if (rd_stb) begin
      snap_q <= resolved;
      int_n  <= 1'b1;
    end else if (resolved != snap_q) begin
      int_n <= 1'b0;
    end
  end

  p_int_assert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !rd_stb && (resolved != snap_q)) |=> !int_n);

  p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb) |=> int_n);

  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(pin_out));
endmodule

// File: rtl/xp_expander.sv
module xp_expander
  import xp_pkg::*;
#(
  parameter logic [XP_LINES-2:0] DEV_ADDR = 7'h2A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [XP_LINES-1:0] pin_i,
  output logic [XP_LINES-1:0] pin_o,
  output logic                int_n_o
);
  logic [XP_LINES-1:0] pin_sync, wr_byte, rd_byte;
  logic                wr_stb, rd_stb;

  xp_sync #(.W(XP_LINES), .RST_VAL('1)) u_pin_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_i),
    .q    (pin_sync)
  );

  xp_i2c_target #(.DATA_W(XP_LINES), .DEV_ADDR(DEV_ADDR)) u_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .rd_byte(rd_byte),
    .sda_oe (sda_oe_o),
    .wr_stb (wr_stb),
    .wr_byte(wr_byte),
    .rd_stb (rd_stb)
  );

  xp_port_core #(.W(XP_LINES)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_sync(pin_sync),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .rd_stb  (rd_stb),
    .rd_byte (rd_byte),
    .pin_out (pin_o),
    .int_n   (int_n_o)
  );
endmodule

// File: tb/xp_expander_tb_top.sv
module xp_expander_tb_top;
  localparam logic [6:0] ADDR = 7'h2A;
  localparam int         Q    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_tb = 1'b1, sda_tb = 1'b1;
  logic [7:0] pins = 8'hFF;
  logic       sda_oe;
  logic [7:0] pin_o;
  logic       int_n;
  wire        sda_line = sda_tb & ~sda_oe;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  xp_expander #(.DEV_ADDR(ADDR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_tb), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pin_i(pins), .pin_o(pin_o), .int_n_o(int_n)
  );

  // each entry: {latch byte, external pin levels}
  localparam logic [15:0] VEC [5] = '{
    {8'hFF, 8'hFF}, {8'h0F, 8'hFF}, {8'hFF, 8'hA5},
    {8'h3C, 8'h5A}, {8'h00, 8'hFF}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2c_start();
    sda_tb = 1'b1; tick(Q); scl_tb = 1'b1; tick(Q);
    sda_tb = 1'b0; tick(Q); scl_tb = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_tb = 1'b0; tick(Q); scl_tb = 1'b1; tick(Q);
    sda_tb = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_tb = b[i]; tick(Q); scl_tb = 1'b1; tick(Q); scl_tb = 1'b0; tick(Q);
    end
    sda_tb = 1'b1; tick(Q); scl_tb = 1'b1; tick(Q);
    ack = sda_line; scl_tb = 1'b0; tick(Q);
  endtask

  task automatic recv_bits(output logic [7:0] b);
    sda_tb = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_tb = 1'b1; tick(Q); b[i] = sda_line; scl_tb = 1'b0;
    end
    tick(Q);
  endtask

  task automatic ctl_ack(input logic nack);
    sda_tb = nack; tick(Q); scl_tb = 1'b1; tick(Q); scl_tb = 1'b0; tick(Q);
    sda_tb = 1'b1;
  endtask

  task automatic wr1(input logic [7:0] d);
    logic a;
    i2c_start();
    send_byte({ADDR, 1'b0}, a); chk("R11 addr ack", {7'd0, a}, 8'h00);
    send_byte(d, a);            chk("R11 data ack", {7'd0, a}, 8'h00);
    i2c_stop(); tick(4);
  endtask

  task automatic rd1(output logic [7:0] d);
    logic a;
    i2c_start();
    send_byte({ADDR, 1'b1}, a); chk("R11 read addr ack", {7'd0, a}, 8'h00);
    recv_bits(d); ctl_ack(1'b1);
    i2c_stop(); tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r, r2;
    logic a;
    tick(3); rst_n = 1'b1; tick(4);
    // R1 reset state
    chk("R1 pin_o", pin_o, 8'hFF);
    chk("R1 int_n", {7'd0, int_n}, 8'h01);
    chk("R1 sda idle", {7'd0, sda_oe}, 8'h00);
    rd1(r); chk("R1 read", r, 8'hFF);

    // R2 R3 R6 vector walk
    foreach (VEC[k]) begin
      pins = VEC[k][7:0]; tick(6);
      wr1(VEC[k][15:8]);
      chk("R2 pin_o after write", pin_o, VEC[k][15:8] & VEC[k][7:0]);
      rd1(r);
      chk("R3 read level", r, VEC[k][15:8] & VEC[k][7:0]);
      chk("R6 int after read", {7'd0, int_n}, 8'h01);
    end
    // snapshot now 00, pins FF
    wr1(8'hFF);
    chk("R7 int low after write", {7'd0, int_n}, 8'h00);
    rd1(r); chk("R3 read FF", r, 8'hFF);
    chk("R6 int released", {7'd0, int_n}, 8'h01);

    pins = 8'hF0; tick(6);
    chk("R8 pin_o holds", pin_o, 8'hFF);
    chk("R5 int asserted", {7'd0, int_n}, 8'h00);
    pins = 8'hFF; tick(6);
    chk("R5 int stays low", {7'd0, int_n}, 8'h00);
    rd1(r); chk("R6 int after read", {7'd0, int_n}, 8'h01);

    // R7: snapshot FF
    wr1(8'h0F); chk("R7 int differs", {7'd0, int_n}, 8'h00);
    wr1(8'hFF); chk("R7 int equal", {7'd0, int_n}, 8'h01);

    // R4 foreign address
    i2c_start();
    send_byte({ADDR ^ 7'h40, 1'b0}, a); chk("R4 nack", {7'd0, a}, 8'h01);
    send_byte(8'h00, a);
    i2c_stop(); tick(4);
    chk("R4 pin_o kept", pin_o, 8'hFF);
    rd1(r); chk("R4 latch kept", r, 8'hFF);

    // R9 multi-byte write
    i2c_start();
    send_byte({ADDR, 1'b0}, a); chk("R11 addr", {7'd0, a}, 8'h00);
    send_byte(8'h12, a);        chk("R11 byte1", {7'd0, a}, 8'h00);
    tick(4); chk("R9 first byte", pin_o, 8'h12);
    send_byte(8'h34, a);        chk("R11 byte2", {7'd0, a}, 8'h00);
    i2c_stop(); tick(4);
    chk("R9 last byte", pin_o, 8'h34);

    // R10 multi-byte read with a change between bytes
    wr1(8'hFF);
    i2c_start();
    send_byte({ADDR, 1'b1}, a);
    recv_bits(r);
    pins = 8'h81; tick(6);
    ctl_ack(1'b0);
    recv_bits(r2); ctl_ack(1'b1);
    i2c_stop(); tick(4);
    chk("R10 byte1", r, 8'hFF);
    chk("R10 byte2 fresh", r2, 8'h81);
    chk("R10 R6 snapshot from byte2", {7'd0, int_n}, 8'h01);
    chk("R10 sda released", {7'd0, sda_oe}, 8'h00);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule